// File: doc/BRIEF.md
# Dual-Bank Clock Output Controller

This block is the digital control path of a two-bank clock generator. An external frequency synthesizer produces one clock per bank; this block tells the synthesizer which multiplier each bank needs, passes on the spread-spectrum request and its width, and drives five gated clocks per bank plus one gated copy of the reference clock. Each bank's multiplier code and the spread request come either from hardware pins or from a function configuration byte. One bit of that byte chooses the source.

Each output has a register enable that switches only while the clock it gates is low, so a register-driven change never produces a runt pulse. A disabled output is driven low. Separately, two bank enable pins produce per-output tri-state controls, and these act at once. A test mode replaces the synthesizer clocks with divided copies of the reference: divide-by-6 on bank A and divide-by-4 on bank B.

Top module: `dbclk_ctrl`

## Requirements
- R1: `mult_a_sel` and `mult_b_sel` are one-hot. Bit k set means a multiplier of (k+1) times the reference, for frequency code k = {S1,S0}: 00 is 1x, 01 is 2x, 10 is 3x, 11 is 4x. The two banks are independent.
- R2: When `cfg_func[0]` is 1, each bank's code comes from its select pins. When it is 0, bank A's code is {`cfg_func[2]`,`cfg_func[1]`} and bank B's code is {`cfg_func[4]`,`cfg_func[3]`}.
- R3: In pin mode, `spread_en` is the inverse of `spread_pin_n`. In register mode, `spread_en` equals `cfg_func[6]` and the pin has no effect.
- R4: `spread_half` equals `cfg_func[5]`: 1 requests a 0.5% down-spread and 0 requests a 1.0% down-spread.
- R5: Every bit of `clk_a_oe` equals `oe_a_pin`, and every bit of `clk_b_oe` equals `oe_b_pin`. `ref_oe` is high only when both bank enable pins are high.
- R6: `cfg_ena_a[i]` enables `clk_a_out[i]`, `cfg_ena_b[i]` enables `clk_b_out[i]`, and `cfg_ena_a[5]` enables `ref_out`. An enabled output follows its source clock. A disabled output stays low while its tri-state control is unaffected.
- R7: A change to a register enable takes effect only at the next falling edge of the gated source. A high pulse already in progress is neither cut short nor started late.
- R8: `cfg_func[7]` = 0 selects test mode. Bank A then carries reference/6 and bank B carries reference/4, both with 50% duty, and `ref_out` continues to carry the reference.
- R9: Both dividers are held cleared outside test mode. After entry into test mode, bank A first rises on the third rising reference edge and bank B on the second.
- R10: While `rst_n` is low, all gated clock outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock, also the test divider clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| syn_a_clk | input | 1 | Synthesizer clock for bank A |
| syn_b_clk | input | 1 | Synthesizer clock for bank B |
| sel_a_pin | input | 2 | Bank A frequency code pins {S1,S0} |
| sel_b_pin | input | 2 | Bank B frequency code pins {S1,S0} |
| spread_pin_n | input | 1 | Spread request pin, active low |
| oe_a_pin | input | 1 | Bank A output enable pin |
| oe_b_pin | input | 1 | Bank B output enable pin |
| cfg_func | input | 8 | Function configuration byte |
| cfg_ena_a | input | 6 | Bank A output enables, bit 5 enables the reference output |
| cfg_ena_b | input | 5 | Bank B output enables |
| mult_a_sel | output | 4 | One-hot multiplier select for bank A |
| mult_b_sel | output | 4 | One-hot multiplier select for bank B |
| spread_en | output | 1 | Spread-spectrum request to the modulator |
| spread_half | output | 1 | Spread width, 1 = 0.5%, 0 = 1.0% |
| clk_a_out | output | 5 | Gated bank A clocks |
| clk_a_oe | output | 5 | Bank A tri-state controls, 1 = drive |
| clk_b_out | output | 5 | Gated bank B clocks |
| clk_b_oe | output | 5 | Bank B tri-state controls, 1 = drive |
| ref_out | output | 1 | Gated reference clock |
| ref_oe | output | 1 | Reference tri-state control, 1 = drive |

## Verification
The bench drops a register enable while the source clock is high and raises one in the same phase. A plain AND gate would cut the pulse short or start one late, and the bench would see it. The bench enters test mode on a known reference edge and compares the first twelve samples of each bank with the exact divided waveform. A counter that is not cleared outside test mode would then show an arbitrary phase, and a wrong terminal count would show a wrong duty cycle. Random configuration bytes switch between pin and register control. This exposes a swapped code field, an inverted spread polarity, or a reference tri-state that tracks only one bank pin.

// File: rtl/dbclk_pkg.sv
package dbclk_pkg;
  localparam int CODE_W = 2;
  localparam int SEL_W  = 1 << CODE_W;

  // function byte field positions
  localparam int F_PINMODE = 0;
  localparam int F_A_LO    = 1;
  localparam int F_B_LO    = 3;
  localparam int F_HALF    = 5;
  localparam int F_SPREAD  = 6;
  localparam int F_NORMAL  = 7;

  function automatic logic [SEL_W-1:0] code_to_sel(input logic [CODE_W-1:0] code);
    logic [SEL_W-1:0] sel;
    sel = '0;
    sel[code] = 1'b1;
    return sel;
  endfunction
endpackage

// File: rtl/dbclk_mode_sel.sv
module dbclk_mode_sel
  import dbclk_pkg::*;
(
  input  logic [CODE_W-1:0] sel_a_pin,
  input  logic [CODE_W-1:0] sel_b_pin,
  input  logic              spread_pin_n,
  input  logic [7:0]        cfg_func,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              spread_en,
  output logic              spread_half,
  output logic              test_mode
);
  logic pin_mode;

  always_comb begin
    pin_mode    = cfg_func[F_PINMODE];
    test_mode   = ~cfg_func[F_NORMAL];
    spread_half = cfg_func[F_HALF];
    if (pin_mode) begin
      code_a    = sel_a_pin;
      code_b    = sel_b_pin;
      spread_en = ~spread_pin_n;
    end else begin
      code_a    = cfg_func[F_A_LO +: CODE_W];
      code_b    = cfg_func[F_B_LO +: CODE_W];
      spread_en = cfg_func[F_SPREAD];
    end
  end
endmodule

// File: rtl/dbclk_test_div.sv
module dbclk_test_div #(
  parameter int DIV = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic div_out
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          q_q, q_d;

  always_comb begin
    cnt_d = cnt_q;
    q_d   = q_q;
    if (!run) begin
      cnt_d = '0;
      q_d   = 1'b0;
    end else if (cnt_q == CW'(HALF - 1)) begin
      cnt_d = '0;
      q_d   = ~q_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      q_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      q_q   <= q_d;
    end
  end

  assign div_out = q_q;
endmodule

// File: rtl/dbclk_gate_bank.sv
module dbclk_gate_bank #(
  parameter int N = 5
) (
  input  logic         src_clk,
  input  logic         rst_n,
  input  logic [N-1:0] en,
  output logic [N-1:0] clk_out
);
  logic [N-1:0] en_q;

  for (genvar i = 0; i < N; i++) begin : g_gate
    // enable captured on the falling edge, so it only moves while src is low
    always_ff @(negedge src_clk or negedge rst_n) begin
      if (!rst_n) en_q[i] <= 1'b0;
      else        en_q[i] <= en[i];
    end
    assign clk_out[i] = src_clk & en_q[i];
  end
endmodule

// File: rtl/dbclk_ctrl.sv
module dbclk_ctrl
  import dbclk_pkg::*;
#(
  parameter int NUM_OUT = 5,
  parameter int DIV_A   = 6,
  parameter int DIV_B   = 4
) (
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic               syn_a_clk,
  input  logic               syn_b_clk,
  input  logic [CODE_W-1:0]  sel_a_pin,
  input  logic [CODE_W-1:0]  sel_b_pin,
  input  logic               spread_pin_n,
  input  logic               oe_a_pin,
  input  logic               oe_b_pin,
  input  logic [7:0]         cfg_func,
  input  logic [NUM_OUT:0]   cfg_ena_a,
  input  logic [NUM_OUT-1:0] cfg_ena_b,
  output logic [SEL_W-1:0]   mult_a_sel,
  output logic [SEL_W-1:0]   mult_b_sel,
  output logic               spread_en,
  output logic               spread_half,
  output logic [NUM_OUT-1:0] clk_a_out,
  output logic [NUM_OUT-1:0] clk_a_oe,
  output logic [NUM_OUT-1:0] clk_b_out,
  output logic [NUM_OUT-1:0] clk_b_oe,
  output logic               ref_out,
  output logic               ref_oe
);
  localparam int REF_BIT = NUM_OUT;

  logic [CODE_W-1:0] code_a, code_b;
  logic              test_mode;
  logic [1:0]        rst_sync_q;
  logic              rst_ref_n;
  logic              div_a_clk, div_b_clk;
  logic              src_a_clk, src_b_clk;
  logic [0:0]        ref_gated;

  dbclk_mode_sel u_mode (
    .sel_a_pin    (sel_a_pin),
    .sel_b_pin    (sel_b_pin),
    .spread_pin_n (spread_pin_n),
    .cfg_func     (cfg_func),
    .code_a       (code_a),
    .code_b       (code_b),
    .spread_en    (spread_en),
    .spread_half  (spread_half),
    .test_mode    (test_mode)
  );

  assign mult_a_sel = code_to_sel(code_a);
  assign mult_b_sel = code_to_sel(code_b);

  // reset released synchronously to the reference clock
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ref_n = rst_sync_q[1];

  dbclk_test_div #(.DIV(DIV_A)) u_div_a (
    .clk (ref_clk), .rst_n (rst_ref_n), .run (test_mode), .div_out (div_a_clk)
  );
  dbclk_test_div #(.DIV(DIV_B)) u_div_b (
    .clk (ref_clk), .rst_n (rst_ref_n), .run (test_mode), .div_out (div_b_clk)
  );

  always_comb begin
    src_a_clk = test_mode ? div_a_clk : syn_a_clk;
    src_b_clk = test_mode ? div_b_clk : syn_b_clk;
  end

  dbclk_gate_bank #(.N(NUM_OUT)) u_gate_a (
    .src_clk (src_a_clk), .rst_n (rst_n), .en (cfg_ena_a[NUM_OUT-1:0]), .clk_out (clk_a_out)
  );
  dbclk_gate_bank #(.N(NUM_OUT)) u_gate_b (
    .src_clk (src_b_clk), .rst_n (rst_n), .en (cfg_ena_b), .clk_out (clk_b_out)
  );
  dbclk_gate_bank #(.N(1)) u_gate_ref (
    .src_clk (ref_clk), .rst_n (rst_n), .en (cfg_ena_a[REF_BIT]), .clk_out (ref_gated)
  );
  assign ref_out = ref_gated[0];

  // pin-driven tri-state controls act immediately
  assign clk_a_oe = {NUM_OUT{oe_a_pin}};
  assign clk_b_oe = {NUM_OUT{oe_b_pin}};
  assign ref_oe   = oe_a_pin & oe_b_pin;
endmodule

// File: rtl/dbclk_ctrl_chk.sv
module dbclk_ctrl_chk (
  input logic       ref_clk,
  input logic       rst_n,
  input logic       spread_pin_n,
  input logic       oe_a_pin,
  input logic       oe_b_pin,
  input logic [7:0] cfg_func,
  input logic [3:0] mult_a_sel,
  input logic [3:0] mult_b_sel,
  input logic       spread_en,
  input logic       ref_oe,
  input logic       div_a,
  input logic       div_b
);
  AST_SEL_A_ONEHOT: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $countones(mult_a_sel) == 1); // R1
  AST_SEL_B_ONEHOT: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $countones(mult_b_sel) == 1); // R1
  AST_PIN_SPREAD: assert property (@(posedge ref_clk) disable iff (!rst_n)
    cfg_func[0] |-> (spread_en != spread_pin_n)); // R3
  AST_REG_SPREAD: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !cfg_func[0] |-> (spread_en == cfg_func[6])); // R3
  AST_REF_TRISTATE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!oe_a_pin || !oe_b_pin) |-> !ref_oe); // R5
  AST_DIV_A_WIDTH: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!cfg_func[7] && $rose(div_a)) |=> div_a); // R8
  AST_DIV_IDLE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    cfg_func[7] |=> (!div_a && !div_b)); // R9
endmodule

bind dbclk_ctrl dbclk_ctrl_chk u_chk (
  .ref_clk      (ref_clk),
  .rst_n        (rst_n),
  .spread_pin_n (spread_pin_n),
  .oe_a_pin     (oe_a_pin),
  .oe_b_pin     (oe_b_pin),
  .cfg_func     (cfg_func),
  .mult_a_sel   (mult_a_sel),
  .mult_b_sel   (mult_b_sel),
  .spread_en    (spread_en),
  .ref_oe       (ref_oe),
  .div_a        (div_a_clk),
  .div_b        (div_b_clk)
);

// File: tb/dbclk_ctrl_tb_top.sv
module dbclk_ctrl_tb_top;
  logic       ref_clk = 1'b0;
  logic       syn_a_clk = 1'b0;
  logic       syn_b_clk = 1'b0;
  logic       rst_n;
  logic [1:0] sel_a_pin, sel_b_pin;
  logic       spread_pin_n, oe_a_pin, oe_b_pin;
  logic [7:0] cfg_func;
  logic [5:0] cfg_ena_a;
  logic [4:0] cfg_ena_b;
  logic [3:0] mult_a_sel, mult_b_sel;
  logic       spread_en, spread_half;
  logic [4:0] clk_a_out, clk_a_oe, clk_b_out, clk_b_oe;
  logic       ref_out, ref_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 ref_clk   = ~ref_clk;   // 125 MHz
  always #3 syn_a_clk = ~syn_a_clk;
  always #5 syn_b_clk = ~syn_b_clk;

  dbclk_ctrl dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_sel(input logic [7:0] f, input logic [1:0] pins, input bit bank_b);
    logic [1:0] c;
    if (f[0]) c = pins;
    else      c = bank_b ? f[4:3] : f[2:1];
    return 4'b0001 << c;
  endfunction

  function automatic logic exp_spread(input logic [7:0] f, input logic pin_n);
    return f[0] ? ~pin_n : f[6];
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd5309));
    rst_n = 1'b0;
    sel_a_pin = 2'b00; sel_b_pin = 2'b00;
    spread_pin_n = 1'b1; oe_a_pin = 1'b1; oe_b_pin = 1'b1;
    cfg_func = 8'hA1; cfg_ena_a = 6'h3F; cfg_ena_b = 5'h1F;
    repeat (5) @(negedge ref_clk);
    chk("R10 bank A low in reset", 32'(clk_a_out), 0);
    chk("R10 bank B low in reset", 32'(clk_b_out), 0);
    chk("R10 ref low in reset", 32'(ref_out), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge ref_clk);

    // random configuration sweep (normal mode only)
    for (int it = 0; it < 40; it++) begin
      logic [7:0] f;
      f = 8'($urandom) | 8'h80;
      if (it < 4) f = (it[0]) ? 8'hA1 : 8'h80 | 8'($urandom) & 8'hFE;
      cfg_func = f;
      sel_a_pin = 2'($urandom); sel_b_pin = 2'($urandom);
      spread_pin_n = 1'($urandom);
      oe_a_pin = 1'($urandom); oe_b_pin = 1'($urandom);
      cfg_ena_a = 6'($urandom); cfg_ena_b = 5'($urandom);
      #1;
      chk("R1 R2 bank A select", 32'(mult_a_sel), 32'(exp_sel(f, sel_a_pin, 1'b0)));
      chk("R1 R2 bank B select", 32'(mult_b_sel), 32'(exp_sel(f, sel_b_pin, 1'b1)));
      chk("R3 spread enable", 32'(spread_en), 32'(exp_spread(f, spread_pin_n)));
      chk("R4 spread width", 32'(spread_half), 32'(f[5]));
      chk("R5 bank A oe", 32'(clk_a_oe), 32'({5{oe_a_pin}}));
      chk("R5 bank B oe", 32'(clk_b_oe), 32'({5{oe_b_pin}}));
      chk("R5 ref oe", 32'(ref_oe), 32'(oe_a_pin & oe_b_pin));
      repeat (3) @(posedge syn_b_clk);
      @(posedge syn_a_clk); #1;
      chk("R6 bank A high phase", 32'(clk_a_out), 32'(cfg_ena_a[4:0]));
      @(negedge syn_a_clk); #1;
      chk("R6 bank A low phase", 32'(clk_a_out), 0);
      @(posedge syn_b_clk); #1;
      chk("R6 bank B high phase", 32'(clk_b_out), 32'(cfg_ena_b));
      @(posedge ref_clk); #1;
      chk("R6 ref high phase", 32'(ref_out), 32'(cfg_ena_a[5]));
    end

    // R7: enable changes while the source is high
    cfg_func = 8'hA1; oe_a_pin = 1'b1; oe_b_pin = 1'b1;
    cfg_ena_a = 6'h3F; cfg_ena_b = 5'h1F;
    repeat (3) @(posedge syn_a_clk);
    #1 cfg_ena_a[0] = 1'b0;
    #1 chk("R7 pulse not cut short", 32'(clk_a_out[0]), 1);
    @(posedge syn_a_clk); #1;
    chk("R7 disable after fall", 32'(clk_a_out[0]), 0);
    chk("R6 oe kept while disabled", 32'(clk_a_oe[0]), 1);
    cfg_ena_a[0] = 1'b1;
    #1 chk("R7 no late start", 32'(clk_a_out[0]), 0);
    @(posedge syn_a_clk); #1;
    chk("R7 enable after fall", 32'(clk_a_out[0]), 1);

    // R5 corner: one bank pin low
    oe_a_pin = 1'b0; #1;
    chk("R5 ref tri-state from A", 32'(ref_oe), 0);
    chk("R5 bank B unaffected", 32'(clk_b_oe), 32'h1F);
    oe_a_pin = 1'b1; oe_b_pin = 1'b0; #1;
    chk("R5 ref tri-state from B", 32'(ref_oe), 0);
    chk("R5 bank A unaffected", 32'(clk_a_oe), 32'h1F);
    oe_b_pin = 1'b1;

    // R8/R9: test mode entry
    @(negedge ref_clk);
    cfg_func[7] = 1'b0;
    for (int s = 1; s <= 12; s++) begin
      logic ea, eb;
      @(negedge ref_clk); #1;
      ea = (s >= 3) && (((s - 3) % 6) < 3);
      eb = (s >= 2) && (((s - 2) % 4) < 2);
      chk("R8 R9 bank A divide by 6", 32'(clk_a_out), 32'({5{ea}}));
      chk("R8 R9 bank B divide by 4", 32'(clk_b_out), 32'({5{eb}}));
    end
    @(posedge ref_clk); #1;
    chk("R8 ref passes in test", 32'(ref_out), 1);
    @(negedge ref_clk); #1;
    chk("R8 ref low phase in test", 32'(ref_out), 0);

    // back to normal mode
    cfg_func[7] = 1'b1;
    repeat (4) @(negedge ref_clk);
    @(posedge syn_b_clk); #1;
    chk("R8 bank B back on synthesizer", 32'(clk_b_out), 32'h1F);

    finish_run();
  end
endmodule